// File: doc/BRIEF.md
# Unit-Stride Vector Load Distributor

This block moves the result of a unit-stride vector word load from a shared data cache into a row of parallel vector lanes. A load is started with a starting word address and an element count. The block then requests cache lines one after another. From every line it receives, it sends each useful 32-bit word to the lane whose element number equals that word's distance from the starting address, and it raises that lane's write strobe for one cycle.

The lane count and the number of words per cache line are parameters, so a single access can fill one lane group or all lanes. A start address that is not aligned to a line makes the first access skip the leading words. It can also add one more access to the load. While the cache reports a miss, the block holds its request and waits. It then continues from the same element. When the last element has been delivered, a one-cycle completion pulse is raised.

Top module: `vec_load_xbar`

## Requirements
- R1: While reset is held and after it is released, with no load running, `busy`, `done`, `reqValid` and every bit of `laneStrobe` are 0.
- R2: A load of `vl` elements (1..LANES) starting at word address `b` takes exactly ceil(((b mod LINE_WORDS) + vl) / LINE_WORDS) hit accesses. A hit access is a cycle with `reqValid`=1 and `cacheMiss`=0.
- R3: Over one load, each lane k < `vl` is strobed exactly once, and its `laneData` slice (bits 32k+31..32k) then holds the memory word at address b+k. Within a line, word w sits at bits 32w+31..32w of `cacheData`. A `vecLen` above LANES is treated as LANES.
- R4: Lanes with index >= `vl` are never strobed during that load.
- R5: In a cycle with `reqValid`=1 and `cacheMiss`=1, no lane is strobed on the following cycle and `reqLineAddr` is unchanged on the following cycle.
- R6: `done` is high for exactly one cycle per load. It rises together with the strobes of the final access, and `busy` is 0 in that cycle.
- R7: A load with `vecLen`=0 makes no cache request and raises `done` in the cycle after the start.
- R8: A `startValid` that arrives while `busy` is 1 is ignored, and the running load's results are unchanged.
- R9: The first request uses line address floor(b / LINE_WORDS). Each hit access increments the line address by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a load (taken only when idle) |
| baseAddr | input | ADDR_W | Word address of element 0 |
| vecLen | input | $clog2(LANES+1) | Element count |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| reqValid | output | 1 | Cache line request |
| reqLineAddr | output | ADDR_W-log2(LINE_WORDS) | Requested line address |
| cacheMiss | input | 1 | Cache cannot answer the current request this cycle |
| cacheData | input | LINE_WORDS*32 | Line contents, word w at bits 32w+31..32w |
| laneData | output | LANES*32 | Per-lane delivered word |
| laneStrobe | output | LANES | Per-lane write strobe |

## Verification
The RTL assertions check four properties on every cycle: a missed request is held with no strobe following it, the line address steps by one after each hit, `done` is a single-cycle pulse, and no strobe reaches a lane at or beyond the vector length. Several results can only be shown by the bench's scenarios, because they depend on the whole load. These are the access count for aligned and unaligned bases, the exact word that lands in each lane, the zero-length case, and the fact that a second start during a load has no effect.

// File: rtl/vlx_pkg.sv
package vlx_pkg;
  localparam int WORD_W = 32;

  // strobes from control to datapath for one cache access
  typedef struct packed {
    logic       load;      // a hit happened this cycle
    logic [7:0] skip;      // leading words of the line not used
    logic [7:0] take;      // number of words used from this line
    logic [7:0] firstLane; // element index of the first used word
  } xbarCtl_t;
endpackage

// File: rtl/vlx_ctrl.sv
module vlx_ctrl
  import vlx_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int LINE_WORDS = 4,
  parameter int ADDR_W     = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                startValid,
  input  logic [ADDR_W-1:0]                   baseAddr,
  input  logic [$clog2(LANES+1)-1:0]          vecLen,
  input  logic                                cacheMiss,
  output logic                                busy,
  output logic                                done,
  output logic                                reqValid,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] reqLineAddr,
  output logic [$clog2(LANES+1)-1:0]          vlHeld,
  output xbarCtl_t                            ctl
);
  localparam int LW_LOG   = $clog2(LINE_WORDS);
  localparam int VL_W     = $clog2(LANES+1);
  localparam int LINE_A_W = ADDR_W - LW_LOG;

  logic              busyQ, doneQ;
  logic [ADDR_W-1:0] addrQ;
  logic [VL_W-1:0]   idxQ, vlQ, vlIn;
  int                offI, takeI, remainI;
  logic              hit, lastHit;

  assign vlIn = (int'(vecLen) > LANES) ? VL_W'(LANES) : vecLen;

  always_comb begin
    offI    = int'(addrQ[LW_LOG-1:0]);
    remainI = int'(vlQ) - int'(idxQ);
    takeI   = ((LINE_WORDS - offI) < remainI) ? (LINE_WORDS - offI) : remainI;
  end

  assign hit     = busyQ & ~cacheMiss;
  assign lastHit = hit && (takeI == remainI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      addrQ <= '0;
      idxQ  <= '0;
      vlQ   <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (startValid) begin
          addrQ <= baseAddr;
          idxQ  <= '0;
          vlQ   <= vlIn;
          if (vlIn == '0) doneQ <= 1'b1;
          else            busyQ <= 1'b1;
        end
      end else if (hit) begin
        addrQ <= addrQ + ADDR_W'(takeI);
        idxQ  <= idxQ + VL_W'(takeI);
        if (lastHit) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign busy        = busyQ;
  assign done        = doneQ;
  assign reqValid    = busyQ;
  assign reqLineAddr = addrQ[ADDR_W-1:LW_LOG];
  assign vlHeld      = vlQ;

  always_comb begin
    ctl.load      = hit;
    ctl.skip      = 8'(offI);
    ctl.take      = 8'(takeI);
    ctl.firstLane = 8'(idxQ);
  end

  // a missed request stays put
  assert_miss_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && cacheMiss) |=> (reqValid && $stable(reqLineAddr)));

  // after a hit that is not the last, the next line is requested
  assert_line_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !lastHit) |=> (reqLineAddr == $past(reqLineAddr) + LINE_A_W'(1)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/vlx_datapath.sv
module vlx_datapath
  import vlx_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  xbarCtl_t                      ctl,
  input  logic [LINE_WORDS*WORD_W-1:0]  cacheData,
  output logic [LANES*WORD_W-1:0]       laneData,
  output logic [LANES-1:0]              laneStrobe
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0][WORD_W-1:0] dataQ;
  logic [LANES-1:0]             strobeQ;
  logic [LINE_WORDS-1:0][LANE_W-1:0] laneSel;
  logic [LINE_WORDS-1:0]             wordUsed;

  // word j of the line goes to the element j-skip past the current index
  for (genvar j = 0; j < LINE_WORDS; j++) begin : g_route
    always_comb begin
      wordUsed[j] = (j >= int'(ctl.skip)) && ((j - int'(ctl.skip)) < int'(ctl.take));
      laneSel[j]  = LANE_W'((int'(ctl.firstLane) + j - int'(ctl.skip)) % LANES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataQ   <= '0;
      strobeQ <= '0;
    end else begin
      strobeQ <= '0;
      for (int j = 0; j < LINE_WORDS; j++) begin
        if (ctl.load && wordUsed[j]) begin
          dataQ[laneSel[j]]   <= cacheData[j*WORD_W +: WORD_W];
          strobeQ[laneSel[j]] <= 1'b1;
        end
      end
    end
  end

  assign laneData   = dataQ;
  assign laneStrobe = strobeQ;

  // one access never feeds more lanes than a line holds
  assert_line_fanout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(laneStrobe) <= LINE_WORDS);

  // a cycle without a hit leaves no strobe behind it
  assert_no_hit_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.load |=> (laneStrobe == '0));
endmodule

// File: rtl/vec_load_xbar.sv
module vec_load_xbar
  import vlx_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int LINE_WORDS = 4,
  parameter int ADDR_W     = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 startValid,
  input  logic [ADDR_W-1:0]                    baseAddr,
  input  logic [$clog2(LANES+1)-1:0]           vecLen,
  output logic                                 busy,
  output logic                                 done,
  output logic                                 reqValid,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] reqLineAddr,
  input  logic                                 cacheMiss,
  input  logic [LINE_WORDS*32-1:0]             cacheData,
  output logic [LANES*32-1:0]                  laneData,
  output logic [LANES-1:0]                     laneStrobe
);
  localparam int VL_W = $clog2(LANES+1);

  xbarCtl_t        ctl;
  logic [VL_W-1:0] vlHeld;
  logic [LANES-1:0] laneMask;

  vlx_ctrl #(.LANES(LANES), .LINE_WORDS(LINE_WORDS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .baseAddr(baseAddr),
    .vecLen(vecLen), .cacheMiss(cacheMiss), .busy(busy), .done(done),
    .reqValid(reqValid), .reqLineAddr(reqLineAddr), .vlHeld(vlHeld), .ctl(ctl)
  );

  vlx_datapath #(.LANES(LANES), .LINE_WORDS(LINE_WORDS)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .cacheData(cacheData),
    .laneData(laneData), .laneStrobe(laneStrobe)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign laneMask[k] = (k < int'(vlHeld));
  end

  assert_lane_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (laneStrobe & ~laneMask) == '0);
endmodule

// File: tb/vec_load_xbar_tb_top.sv
module vec_load_xbar_tb_top;
  localparam int LANES = 16;
  localparam int LW    = 4;
  localparam int AW    = 16;
  localparam int VL_W  = $clog2(LANES+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startValid = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [VL_W-1:0] vecLen = '0;
  logic busy, done, reqValid;
  logic [AW-3:0] reqLineAddr;
  logic cacheMiss = 1'b0;
  logic [LW*32-1:0] cacheData;
  logic [LANES*32-1:0] laneData;
  logic [LANES-1:0] laneStrobe;

  int total = 0;
  int bad = 0;
  bit finishedAll = 0;

  always #10 clk = ~clk;

  vec_load_xbar #(.LANES(LANES), .LINE_WORDS(LW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .baseAddr(baseAddr),
    .vecLen(vecLen), .busy(busy), .done(done), .reqValid(reqValid),
    .reqLineAddr(reqLineAddr), .cacheMiss(cacheMiss), .cacheData(cacheData),
    .laneData(laneData), .laneStrobe(laneStrobe)
  );

  function automatic logic [31:0] memWord(input int a);
    logic [15:0] x;
    x = 16'(a);
    return {x ^ 16'hC3A5, ~x + 16'h0101};
  endfunction

  always_comb begin
    for (int w = 0; w < LW; w++)
      cacheData[w*32 +: 32] = memWord(int'(reqLineAddr) * LW + w);
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runLoad(input int base, input int vlReq, input int missPct, input bit poke);
    int vl;
    int cnt[LANES];
    logic [31:0] got[LANES];
    int hits, dones, cyc, expLine, expHits;
    bit prevHit, prevMiss, fin, r5ok, r9ok;
    logic [AW-3:0] heldLine;
    vl = (vlReq > LANES) ? LANES : vlReq;
    for (int k = 0; k < LANES; k++) begin cnt[k] = 0; got[k] = '0; end
    hits = 0; dones = 0; cyc = 0; fin = 0; r5ok = 1; r9ok = 1;
    expLine = base / LW;
    expHits = (vl == 0) ? 0 : ((base % LW) + vl + LW - 1) / LW;
    heldLine = '0;
    @(negedge clk);
    startValid = 1'b1; baseAddr = AW'(base); vecLen = VL_W'(vlReq);
    @(negedge clk);
    startValid = 1'b0;
    if (done) begin
      dones++; fin = 1;
      // R7: zero length gives done right away with no request
      check(!reqValid && !busy, "R7", "zero-length request", int'(reqValid), 0);
    end
    while (!fin && cyc < 400) begin
      prevHit = 0; prevMiss = 0;
      if (reqValid) begin
        if (int'(reqLineAddr) != (expLine & 16'h3FFF)) r9ok = 0;
        cacheMiss = (($urandom % 100) < missPct);
        prevHit = !cacheMiss; prevMiss = cacheMiss; heldLine = reqLineAddr;
      end
      if (poke && cyc == 1) begin
        startValid = 1'b1; baseAddr = AW'(base + 7); vecLen = VL_W'(2);
      end
      @(negedge clk);
      startValid = 1'b0; cacheMiss = 1'b0;
      cyc++;
      if (prevHit) begin hits++; expLine++; end
      if (prevMiss && (laneStrobe != '0 || reqLineAddr != heldLine)) r5ok = 0;
      for (int k = 0; k < LANES; k++)
        if (laneStrobe[k]) begin cnt[k]++; got[k] = laneData[k*32 +: 32]; end
      if (done) begin
        dones++; fin = 1;
        check(!busy, "R6", "busy with done", int'(busy), 0);
      end
    end
    @(negedge clk);
    check(!done, "R6", "done longer than one cycle", int'(done), 0);
    check(laneStrobe == '0, "R6", "strobe after done", int'(laneStrobe), 0);
    check(dones == 1, "R6", "done count", dones, 1);
    check(hits == expHits, "R2", "hit accesses", hits, expHits);
    if (missPct > 0) check(r5ok, "R5", "miss hold", 0, 1);
    check(r9ok, "R9", "line address sequence", 0, 1);
    for (int k = 0; k < LANES; k++) begin
      if (k < vl) begin
        check(cnt[k] == 1, poke ? "R8" : "R3", "lane strobe count", cnt[k], 1);
        check(got[k] == memWord(base + k), poke ? "R8" : "R3", "lane word",
              int'(got[k]), int'(memWord(base + k)));
      end else begin
        check(cnt[k] == 0, "R4", "strobe beyond length", cnt[k], 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && !reqValid && laneStrobe == '0, "R1", "state in reset",
          int'({busy, done, reqValid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !reqValid && laneStrobe == '0, "R1", "idle after reset",
          int'(laneStrobe), 0);
    runLoad(0, 16, 0, 0);     // aligned, four accesses
    runLoad(5, 16, 0, 0);     // unaligned, one extra access
    runLoad(2, 3, 0, 0);      // short, straddles two lines
    runLoad(8, 1, 0, 0);      // single element
    runLoad(40, 0, 0, 0);     // zero length
    runLoad(3, 16, 60, 0);    // heavy misses
    runLoad(12, 16, 20, 1);   // second start while busy
    runLoad(4, 31, 0, 0);     // length above lane count is clamped
    for (int n = 0; n < 40; n++)
      runLoad(int'($urandom % 4000), int'($urandom % (LANES + 1)), int'($urandom % 50), 0);
    finishedAll = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finishedAll) begin
      total++; bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule